// File: doc/BRIEF.md
# Command-Queue I2C Bus Master

This block is an I2C bus master that runs from a queue of 10-bit command words. Each word holds a byte and two flags. One flag asks for a START condition before the byte, and the other asks for a STOP condition after it. The first byte after a START is treated as the address byte. If its direction bit selects a read, each later command word that carries no START makes the engine clock in one byte from the slave and push that byte into a receive queue. Otherwise the engine shifts the byte out MSB first and samples the slave's acknowledge.

The bus lines are open-drain. `scl_oe` and `sda_oe` high mean "pull the line low", and the block reads the resolved levels back through `scl_in` and `sda_in`. Three cycle counts set the bit timing: SCL low time, SCL high time and SDA hold time after SCL falls. The high time only advances while SCL actually reads high, which tolerates a slave that holds the clock low.

Acknowledge failures, lost arbitration and receive overflow are each reported as a one-cycle event pulse. A software driver above the block reacts to them, for example by queueing a STOP-only word to release the bus.

Top module: `i2c_cmd_master`

## Requirements
- R1: Reset state. After reset, both line drivers are released (`scl_oe`=0, `sda_oe`=0), `busy` is 0, and both queue levels are 0.
- R2: Command word format and write path.
  - Bit 9 requests a START and bit 8 requests a STOP; bits 7:0 carry the byte.
  - From an idle bus, a START word produces a START condition and then sends its byte MSB first.
  - The engine then releases SDA for the acknowledge bit.
  - A word with bit 8 set ends with a STOP condition after its byte.
- R3: Repeated START and direction.
  - A START word issued while the bus is held makes a repeated START.
  - When an address byte with bit 0 = 1 is acknowledged, later words without START receive bytes instead of sending them.
- R4: Receive path.
  - Each receive word clocks in exactly one byte and pushes it to the receive queue; its data bits are ignored.
  - The master drives ACK (SDA low) on every received byte except the one whose word has bit 8 set, which gets NACK.
  - `rx_data` shows the oldest entry, and `rx_pop` removes it.
- R5: Bit timing.
  - SCL is held low for `t_low` cycles.
  - SCL is released for `t_high` cycles, counted only while `scl_in` reads high.
  - SDA changes `t_hold` cycles after SCL is pulled low; this needs 1 <= `t_hold` < `t_low`.
  - SDA never changes while SCL is high inside a data or acknowledge bit.
- R6: `busy` is 1 while any command is queued or a bus sequence is in progress, and 0 otherwise.
- R7: NACK handling.
  - If SDA reads high during the acknowledge bit of a sent byte, `nack_evt` pulses for one cycle.
  - Later words with neither START nor STOP are then dropped without bus activity.
  - A STOP word then produces only a STOP condition, with no byte.
- R8: Arbitration loss.
  - If SDA reads low while the engine releases it for a sent data bit with SCL high, `arb_evt` pulses.
  - Both lines are released in that same cycle, and the bus is no longer held.
  - Later words without START are dropped.
- R9: Receive overflow. If a received byte completes while the receive queue holds DEPTH entries, the byte is dropped, `rxovf_evt` pulses, and the stored entries stay unchanged.
- R10: Queue levels.
  - `cmd_level` and `rx_level` count the stored entries, never above DEPTH.
  - `cmd_full` is high at DEPTH.
  - A push into a full command queue is ignored.
- R11: Disable.
  - While `enable` is low, the next cycle shows idle, both queues empty and both lines released.
  - Pushes are ignored while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low flushes all state |
| cmd_push | input | 1 | Write one command word into the queue |
| cmd_word | input | 10 | Command word: [9] START, [8] STOP, [7:0] byte |
| cmd_full | output | 1 | Command queue holds DEPTH entries |
| cmd_level | output | LW | Command queue entry count |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_level | output | LW | Receive queue entry count |
| t_low | input | CW | SCL low time in cycles |
| t_high | input | CW | SCL high time in cycles |
| t_hold | input | CW | SDA hold time after SCL falls, in cycles |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Engine has work or is mid-sequence |
| nack_evt | output | 1 | One-cycle pulse: sent byte not acknowledged |
| arb_evt | output | 1 | One-cycle pulse: arbitration lost |
| rxovf_evt | output | 1 | One-cycle pulse: received byte dropped, queue full |

## Verification
Different kinds of internal fault show up at the ports in different ways and at different times:
- A wrong bit counter or phase timer shows within one bit period, as an SCL low or high run of the wrong length or an SDA edge at the wrong hold offset.
- A corrupted shift register or a wrong direction flag shows at the next acknowledge. The slave model logs a different byte, or the master's ACK/NACK pattern on received bytes departs from the expected one.
- A stale discard or bus-held flag shows as an extra byte, or a missing STOP, after a NACK or an arbitration loss.
- Queue pointer faults show as wrong levels or as out-of-order `rx_data` on the following pop.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DEPTH = 4,
  parameter int CW = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cmd_push,
  input  logic [9:0]    cmd_word,
  output logic          cmd_full,
  output logic [LW-1:0] cmd_level,
  input  logic          rx_pop,
  output logic [7:0]    rx_data,
  output logic [LW-1:0] rx_level,
  input  logic [CW-1:0] t_low,
  input  logic [CW-1:0] t_high,
  input  logic [CW-1:0] t_hold,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          nack_evt,
  output logic          arb_evt,
  output logic          rxovf_evt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RS_LO, S_STA_H1, S_STA_H2, S_BLO, S_BHI, S_STO_LO, S_STO_H1, S_STO_H2
  } st_t;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  st_t            st_q;
  logic [CW-1:0]  tmr;
  logic [3:0]     bitn;
  logic [9:0]     cur;
  logic [7:0]     sh;
  logic           owned, rd_q, disc;

  logic [9:0]     cq [DEPTH];
  logic [AW-1:0]  cwp, crp;
  logic [LW-1:0]  ccnt;
  logic [7:0]     rq [DEPTH];
  logic [AW-1:0]  rwp, rrp;
  logic [LW-1:0]  rcnt;

  wire [9:0] head    = cq[crp];
  wire       c_wr    = enable && cmd_push && (ccnt != LW'(DEPTH));
  wire       take    = enable && (st_q == S_IDLE) && (ccnt != '0);
  wire       lo_done = (tmr == t_low - 1'b1);
  wire       hi_done = scl_in && (tmr == t_high - 1'b1);
  wire       hold_hit = (tmr == t_hold - 1'b1);
  wire       rcv     = rd_q && !cur[9];
  wire       tx_bit  = !rcv && (bitn < 4'd8);
  wire       lost    = (st_q == S_BHI) && scl_in && tx_bit && !sda_oe && !sda_in;
  wire       byte_end = (st_q == S_BHI) && hi_done && (bitn == 4'd8);
  wire       rx_full = (rcnt == LW'(DEPTH));
  wire       r_wr    = byte_end && rcv && !rx_full;
  wire       r_rd    = enable && rx_pop && (rcnt != '0);
  wire       bit_val = (bitn < 4'd8) ? (!rcv && !sh[7]) : (rcv && !cur[8]);

  assign cmd_full  = (ccnt == LW'(DEPTH));
  assign cmd_level = ccnt;
  assign rx_level  = rcnt;
  assign rx_data   = rq[rrp];
  assign busy      = (st_q != S_IDLE) || (ccnt != '0);

  always_ff @(posedge clk) begin
    if (c_wr) cq[cwp] <= cmd_word;
    if (r_wr) rq[rwp] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= '0; crp <= '0; ccnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else if (!enable) begin
      cwp <= '0; crp <= '0; ccnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (c_wr) cwp <= nxt(cwp);
      if (take) crp <= nxt(crp);
      ccnt <= ccnt + LW'(c_wr) - LW'(take);
      if (r_wr) rwp <= nxt(rwp);
      if (r_rd) rrp <= nxt(rrp);
      rcnt <= rcnt + LW'(r_wr) - LW'(r_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; tmr <= '0; bitn <= '0; cur <= '0; sh <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; owned <= 1'b0; rd_q <= 1'b0; disc <= 1'b0;
      nack_evt <= 1'b0; arb_evt <= 1'b0; rxovf_evt <= 1'b0;
    end else if (!enable) begin
      st_q <= S_IDLE; tmr <= '0; bitn <= '0; cur <= '0; sh <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; owned <= 1'b0; rd_q <= 1'b0; disc <= 1'b0;
      nack_evt <= 1'b0; arb_evt <= 1'b0; rxovf_evt <= 1'b0;
    end else begin
      nack_evt <= 1'b0; arb_evt <= 1'b0; rxovf_evt <= 1'b0;
      case (st_q)
        S_IDLE: if (take) begin
          cur <= head; sh <= head[7:0]; tmr <= '0; bitn <= '0;
          if (head[9]) begin
            disc <= 1'b0;
            st_q <= owned ? S_RS_LO : S_STA_H1;
          end else if (owned && !disc) st_q <= S_BLO;
          else if (owned && head[8]) st_q <= S_STO_LO;
        end
        S_RS_LO: begin
          if (hold_hit) sda_oe <= 1'b0;
          if (lo_done) begin scl_oe <= 1'b0; tmr <= '0; st_q <= S_STA_H1; end
          else tmr <= tmr + 1'b1;
        end
        S_STA_H1:
          if (hi_done) begin sda_oe <= 1'b1; tmr <= '0; st_q <= S_STA_H2; end
          else if (scl_in) tmr <= tmr + 1'b1;
        S_STA_H2:
          if (hi_done) begin
            scl_oe <= 1'b1; tmr <= '0; owned <= 1'b1; rd_q <= 1'b0; st_q <= S_BLO;
          end else if (scl_in) tmr <= tmr + 1'b1;
        S_BLO: begin
          if (hold_hit) sda_oe <= bit_val;
          if (lo_done) begin scl_oe <= 1'b0; tmr <= '0; st_q <= S_BHI; end
          else tmr <= tmr + 1'b1;
        end
        S_BHI:
          if (lost) begin
            scl_oe <= 1'b0; sda_oe <= 1'b0; owned <= 1'b0; rd_q <= 1'b0; disc <= 1'b0;
            arb_evt <= 1'b1; st_q <= S_IDLE;
          end else if (hi_done) begin
            scl_oe <= 1'b1; tmr <= '0;
            if (bitn < 4'd8) begin
              sh <= {sh[6:0], sda_in}; bitn <= bitn + 1'b1; st_q <= S_BLO;
            end else begin
              if (rcv) rxovf_evt <= rx_full;
              else if (sda_in) begin nack_evt <= 1'b1; disc <= 1'b1; end
              else if (cur[9]) rd_q <= cur[0];
              st_q <= cur[8] ? S_STO_LO : S_IDLE;
            end
          end else if (scl_in) tmr <= tmr + 1'b1;
        S_STO_LO: begin
          if (hold_hit) sda_oe <= 1'b1;
          if (lo_done) begin scl_oe <= 1'b0; tmr <= '0; st_q <= S_STO_H1; end
          else tmr <= tmr + 1'b1;
        end
        S_STO_H1:
          if (hi_done) begin sda_oe <= 1'b0; tmr <= '0; st_q <= S_STO_H2; end
          else if (scl_in) tmr <= tmr + 1'b1;
        S_STO_H2:
          if (hi_done) begin
            owned <= 1'b0; disc <= 1'b0; rd_q <= 1'b0; tmr <= '0; st_q <= S_IDLE;
          end else if (scl_in) tmr <= tmr + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk #(
  parameter int DEPTH = 4,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          busy,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          scl_in,
  input logic          sda_in,
  input logic [LW-1:0] cmd_level,
  input logic [LW-1:0] rx_level,
  input logic          nack_evt,
  input logic          arb_evt,
  input logic          rxovf_evt,
  input logic          hi_phase
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R10

  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !scl_oe && !sda_oe && cmd_level == '0 && rx_level == '0)); // R11

  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rxovf_evt |-> $past(rx_level) == LW'(DEPTH)); // R9

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_phase && $past(hi_phase) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R5

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_evt |-> (!scl_oe && !sda_oe)); // R8

  AST_NACK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |-> ($past(sda_in) && $past(scl_in))); // R7

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nack_evt, arb_evt, rxovf_evt})); // R7
endmodule

bind i2c_cmd_master i2c_cmd_master_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .busy(busy),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in),
  .cmd_level(cmd_level), .rx_level(rx_level),
  .nack_evt(nack_evt), .arb_evt(arb_evt), .rxovf_evt(rxovf_evt),
  .hi_phase(st_q == S_BHI)
);

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int LO = 8, HI = 6, HOLD = 2;
  localparam logic [6:0] SADDR = 7'h2A;

  logic clk = 0, rst_n = 0, enable = 1;
  logic cmd_push = 0, rx_pop = 0;
  logic [9:0] cmd_word = '0;
  logic cmd_full, scl_oe, sda_oe, busy, nack_evt, arb_evt, rxovf_evt;
  logic [LW-1:0] cmd_level, rx_level;
  logic [7:0] rx_data;
  logic s_sda_low = 0, rogue = 0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_sda_low || rogue);

  always #2 clk = ~clk;

  i2c_cmd_master #(.DEPTH(DEPTH), .CW(16)) i_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cmd_push(cmd_push), .cmd_word(cmd_word), .cmd_full(cmd_full), .cmd_level(cmd_level),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_level(rx_level),
    .t_low(16'(LO)), .t_high(16'(HI)), .t_hold(16'(HOLD)),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .nack_evt(nack_evt), .arb_evt(arb_evt), .rxovf_evt(rxovf_evt));

  int n_chk = 0, n_fail = 0, n_nack = 0, n_arb = 0, n_ovf = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (nack_evt) n_nack++;
    if (arb_evt) n_arb++;
    if (rxovf_evt) n_ovf++;
  end

  // slave model at address SADDR
  int k_idx = -2, starts = 0, stops = 0, wcnt = 0, dcnt = 0, mcnt = 0, nack_idx = -1;
  logic in_addr = 0, addr_ok = 0, rd = 0, s_tx = 0, mack_ok = 0;
  logic [7:0] rxsh = 0, txb = 0, txn = 0;
  logic [7:0] wlog [16];
  logic mlog [16];

  always @(negedge sda_line) if (scl_line) begin
    starts++; k_idx = -1; in_addr = 1; s_tx = 0; s_sda_low = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    stops++; k_idx = -2; s_tx = 0; s_sda_low = 0;
  end
  always @(posedge scl_line) if (k_idx >= 0) begin
    if (k_idx < 8) rxsh = {rxsh[6:0], sda_line};
    else if (s_tx) begin
      mack_ok = !sda_line; mlog[mcnt % 16] = mack_ok; mcnt++;
    end
  end
  always @(negedge scl_line) if (k_idx != -2) begin
    int k;
    k = (k_idx == -1 || k_idx == 8) ? 0 : k_idx + 1;
    if (k == 8) begin
      if (s_tx) s_sda_low = 0;
      else if (in_addr) begin
        addr_ok = (rxsh[7:1] == SADDR); rd = rxsh[0]; s_sda_low = addr_ok; txn = 0; dcnt = 0;
      end else if (addr_ok && !rd) begin
        wlog[wcnt % 16] = rxsh; s_sda_low = (dcnt != nack_idx); wcnt++; dcnt++;
      end else s_sda_low = 0;
    end else begin
      if (k == 0 && k_idx == 8) begin
        s_tx = in_addr ? (addr_ok && rd) : (s_tx && mack_ok);
        in_addr = 0;
        if (s_tx) begin txb = 8'hC0 + txn; txn++; end
      end
      s_sda_low = s_tx ? !txb[7-k] : 1'b0;
    end
    k_idx = k;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w);
    @(negedge clk);
    while (cmd_full) @(negedge clk);
    cmd_word = w; cmd_push = 1;
    @(negedge clk);
    cmd_push = 0;
  endtask

  task automatic raw_push(input logic [9:0] w);
    @(negedge clk);
    cmd_word = w; cmd_push = 1;
    @(negedge clk);
    cmd_push = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input int exp);
    @(negedge clk);
    chk(req, rx_data, exp);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 cmd_level", cmd_level, 0);
    chk("R1 rx_level", rx_level, 0);
  endtask

  task automatic t_timing();
    int n;
    push(10'h254);
    chk("R6 busy after push", busy, 1);
    while (!scl_oe) @(negedge clk);
    n = 0; while (scl_oe) begin n++; @(negedge clk); end
    chk("R5 scl low cycles", n, LO);
    n = 0; while (!scl_oe) begin n++; @(negedge clk); end
    chk("R5 scl high cycles", n, HI);
    n = 0; while (sda_oe) begin n++; @(negedge clk); end
    chk("R5 sda hold cycles", n, HOLD);
    push(10'h13C);
    wait_idle();
    chk("R6 busy after stop", busy, 0);
  endtask

  task automatic t_write();
    int w0 = wcnt, s0 = starts, p0 = stops, nk = n_nack;
    push(10'h254); push(10'h0A5); push(10'h13C);
    wait_idle();
    chk("R2 bytes logged", wcnt - w0, 2);
    chk("R2 first byte", wlog[w0 % 16], 8'hA5);
    chk("R2 second byte", wlog[(w0 + 1) % 16], 8'h3C);
    chk("R2 one start", starts - s0, 1);
    chk("R2 one stop", stops - p0, 1);
    chk("R2 no nack", n_nack - nk, 0);
    chk("R2 bus released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_read();
    int w0 = wcnt, s0 = starts, p0 = stops, m0 = mcnt;
    push(10'h254); push(10'h007);
    push(10'h255); push(10'h0FF); push(10'h0FF); push(10'h1FF);
    wait_idle();
    chk("R3 reg byte logged", wlog[w0 % 16], 8'h07);
    chk("R3 repeated start", starts - s0, 2);
    chk("R3 single stop", stops - p0, 1);
    chk("R4 rx_level", rx_level, 3);
    chk("R4 ack count", mcnt - m0, 3);
    chk("R4 ack byte0", mlog[m0 % 16], 1);
    chk("R4 ack byte1", mlog[(m0 + 1) % 16], 1);
    chk("R4 nack last", mlog[(m0 + 2) % 16], 0);
    pop_chk("R4 data0", 8'hC0);
    pop_chk("R4 data1", 8'hC1);
    pop_chk("R4 data2", 8'hC2);
    chk("R4 rx empty", rx_level, 0);
  endtask

  task automatic t_nack();
    int w0 = wcnt, p0 = stops, nk = n_nack;
    nack_idx = 0;
    push(10'h254); push(10'h011); push(10'h022); push(10'h033); push(10'h100);
    wait_idle();
    nack_idx = -1;
    chk("R7 nack pulses", n_nack - nk, 1);
    chk("R7 discarded bytes", wcnt - w0, 1);
    chk("R7 stop only", stops - p0, 1);
    chk("R7 bus released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_overflow();
    int o0 = n_ovf;
    push(10'h255);
    for (int i = 0; i < 4; i++) push(10'h000);
    push(10'h100);
    wait_idle();
    chk("R9 overflow pulse", n_ovf - o0, 1);
    chk("R9 rx_level full", rx_level, DEPTH);
    for (int i = 0; i < 4; i++) pop_chk("R9 kept data", 8'hC0 + i);
    chk("R10 rx drained", rx_level, 0);
  endtask

  task automatic t_arb();
    int a0 = n_arb, w0 = wcnt;
    push(10'h254); push(10'h099);
    while (!scl_oe) @(negedge clk);
    rogue = 1;
    while (n_arb == a0 && busy) @(negedge clk);
    chk("R8 arb pulse", n_arb - a0, 1);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    rogue = 0;
    wait_idle();
    chk("R8 later byte dropped", wcnt - w0, 0);
    chk("R8 lines idle", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_levels_disable();
    push(10'h254);
    for (int i = 0; i < 4; i++) raw_push(10'h0A0 + i);
    chk("R10 cmd_level", cmd_level, DEPTH);
    chk("R10 cmd_full", cmd_full, 1);
    raw_push(10'h0EE);
    chk("R10 push when full", cmd_level, DEPTH);
    enable = 0;
    @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 cmd flushed", cmd_level, 0);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
    raw_push(10'h0BB);
    chk("R11 push ignored", cmd_level, 0);
    enable = 1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_write();
    t_read();
    t_nack();
    t_overflow();
    t_arb();
    t_levels_disable();
    t_write();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule